// File: doc/BRIEF.md
# Multi-Mode Attenuation Code Controller

This block keeps the 6-bit attenuation setting of a digitally stepped variable gain amplifier and lets one of three update paths change it. One least significant bit of the code is worth 0.5 dB, so the code spans 0 to 31.5 dB of attenuation. Code 0 gives the least attenuation and therefore the highest gain. A two-bit mode input picks the active path. The first path is a 6-bit bus with a hold input. The second is a 16-bit serial frame with readback and a fast-attack input. The third is a pair of step pulses with a selectable step size.

All serial inputs are brought into the system clock domain through two-stage synchronizers. All three paths write the same code register. The output is a registered copy of that register. In serial mode with fast attack raised, the output is instead the register plus a fixed offset. A power-up input drives the amplifier enable. While this input is low, the stored code is frozen.

Top module: `vga_gain_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `gain_code` is 0 and `amp_en` is 0 when `pwr_up` is low.
- R2: Mode `mode_sel`=00 selects the bus path. While `par_hold` is low, the code follows `par_code`. While `par_hold` is high, the code keeps its value.
- R3: Mode 01 selects the serial path. A frame is sent MSB first, with each bit sampled on a rising `spi_sclk` while `spi_csn` is low. Bit 15, the first bit sent, set to 0 marks a write. Bits 5:0 carry the new code. Bits 14:6 are ignored. The write takes effect when `spi_csn` rises.
- R4: A frame holding fewer or more than 16 bits changes nothing.
- R5: A frame whose bit 15 is 1 is a read. After the 10th through the 15th received bit, `spi_sdo_oe` is 1 and `spi_sdo` carries stored code bits 5 down to 0 in that order. The stored code is unchanged. Outside this window, `spi_sdo_oe` is 0.
- R6: In mode 01 with `fast_atk` high, `gain_code` equals the stored code plus 8, limited to 63. When `fast_atk` falls, `gain_code` returns to the stored code. Readback returns the stored code. In any other mode, `fast_atk` has no effect.
- R7: Mode 10 selects the step path. Each rising edge of `atten_up` adds one step to the code, and each rising edge of `atten_dn` subtracts one. `step_sel` values 00, 01, 10 and 11 give steps of 1, 2, 4 and 8. A pulse held high for several cycles counts once.
- R8: Stepping saturates at 63 going up and at 0 going down. It never wraps.
- R9: If rising edges of `atten_up` and `atten_dn` arrive on the same cycle, the code does not change.
- R10: Mode 11 ignores every update path. Switching modes never changes the stored code.
- R11: `amp_en` follows `pwr_up` one cycle later. While `pwr_up` is low, no path changes the stored code. The code is kept through power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Update path: 00 bus, 01 serial, 10 step, 11 none |
| pwr_up | input | 1 | Amplifier power request |
| par_code | input | 6 | Code on the bus path |
| par_hold | input | 1 | High freezes the bus path, low makes it transparent |
| spi_sclk | input | 1 | Serial clock |
| spi_csn | input | 1 | Serial frame select, active low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Readback data out of the block |
| spi_sdo_oe | output | 1 | Drive enable for the shared data line |
| fast_atk | input | 1 | Adds the fast-attack offset in serial mode |
| atten_up | input | 1 | Step pulse toward more attenuation |
| atten_dn | input | 1 | Step pulse toward less attenuation |
| step_sel | input | 2 | Step size select |
| gain_code | output | 6 | Registered attenuation code |
| amp_en | output | 1 | Registered amplifier enable |

## Verification
A bus-path change driven between clock edges is written to the register on the first edge and reaches `gain_code` on the second. The bench checks it exactly two edges later.

A step pulse passes one edge-detect register and then the same two stages. The bench allows three edges for it.

A serial write passes the two-stage synchronizer, the edge detector, a commit register, the code register and the output register. That is about six edges after `spi_csn` rises, and the bench waits ten.

Readback bits and `fast_atk` changes are sampled only after margins longer than their pipelines: eight system clocks per serial half-period, and three edges for the fast-attack change.

// File: rtl/vga_gain_pkg.sv
package vga_gain_pkg;
  typedef enum logic [1:0] {
    MODE_PAR    = 2'b00,
    MODE_SPI    = 2'b01,
    MODE_UPDN   = 2'b10,
    MODE_FROZEN = 2'b11
  } gain_mode_e;
endpackage

// File: rtl/spi_gain_port.sv
module spi_gain_port #(
  parameter int CODE_W     = 6,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sclk,
  input  logic              csn,
  input  logic              sdi,
  input  logic [CODE_W-1:0] cur_code,
  output logic              wr_valid,
  output logic [CODE_W-1:0] wr_code,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W    = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX  = FRAME_BITS + 1;
  localparam int RD_START = FRAME_BITS - CODE_W;
  localparam int IDX_W    = $clog2(CODE_W);

  logic [2:0] s1, s2, s3;
  logic [FRAME_BITS-1:0] sreg;
  logic [CNT_W-1:0] bit_cnt;
  logic rd_flag;
  logic sclk_rise, cs_low, cs_rise, sdi_s;
  logic [CNT_W-1:0] rd_idx;
  logic in_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 3'b010;
      s2 <= 3'b010;
      s3 <= 3'b010;
    end else begin
      s1 <= {sclk, csn, sdi};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign sclk_rise = s2[2] & ~s3[2];
  assign cs_low    = ~s2[1];
  assign cs_rise   = s2[1] & ~s3[1];
  assign sdi_s     = s2[0];
  assign rd_idx    = CNT_W'(FRAME_BITS - 1) - bit_cnt;
  assign in_window = (bit_cnt >= CNT_W'(RD_START)) && (bit_cnt < CNT_W'(FRAME_BITS));
  assign wr_code   = sreg[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      bit_cnt  <= '0;
      rd_flag  <= 1'b0;
      wr_valid <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (cs_low && sclk_rise) begin
        sreg <= {sreg[FRAME_BITS-2:0], sdi_s};
        if (bit_cnt == '0) rd_flag <= sdi_s;
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
      if (!cs_low) begin
        bit_cnt <= '0;
        rd_flag <= 1'b0;
      end
      if (cs_rise)
        wr_valid <= enable && (bit_cnt == CNT_W'(FRAME_BITS)) && !rd_flag;
      sdo_oe <= enable && cs_low && rd_flag && in_window;
      sdo    <= in_window ? cur_code[rd_idx[IDX_W-1:0]] : 1'b0;
    end
  end

  // R4: a commit is issued only for a frame of exactly FRAME_BITS bits
  a_r4_full_frame_only: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS)));

  // R5: readback drive only inside a read frame
  a_r5_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> $past(rd_flag));
endmodule

// File: rtl/updn_stepper.sv
module updn_stepper #(
  parameter int CODE_W     = 6,
  parameter int STEP_SEL_W = 2
) (
  input  logic [CODE_W-1:0]     cur,
  input  logic                  up_evt,
  input  logic                  dn_evt,
  input  logic [STEP_SEL_W-1:0] step_sel,
  output logic [CODE_W-1:0]     nxt
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] CODE_MAX = SUM_W'((1 << CODE_W) - 1);

  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] sum;

  always_comb begin
    step = SUM_W'(1) << step_sel;
    sum  = {1'b0, cur} + step;
    nxt  = cur;
    if (up_evt && !dn_evt)
      nxt = (sum > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : sum[CODE_W-1:0];
    else if (dn_evt && !up_evt)
      nxt = ({1'b0, cur} < step) ? '0 : CODE_W'({1'b0, cur} - step);
  end
endmodule

// File: rtl/vga_gain_ctrl.sv
module vga_gain_ctrl #(
  parameter int CODE_W     = 6,
  parameter int FRAME_BITS = 16,
  parameter int FA_OFFSET  = 8,
  parameter int STEP_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            mode_sel,
  input  logic                  pwr_up,
  input  logic [CODE_W-1:0]     par_code,
  input  logic                  par_hold,
  input  logic                  spi_sclk,
  input  logic                  spi_csn,
  input  logic                  spi_sdi,
  output logic                  spi_sdo,
  output logic                  spi_sdo_oe,
  input  logic                  fast_atk,
  input  logic                  atten_up,
  input  logic                  atten_dn,
  input  logic [STEP_SEL_W-1:0] step_sel,
  output logic [CODE_W-1:0]     gain_code,
  output logic                  amp_en
);
  import vga_gain_pkg::*;

  localparam int SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] CODE_MAX = SUM_W'((1 << CODE_W) - 1);

  gain_mode_e mode;
  logic [CODE_W-1:0] prog_code, next_code, step_code, wr_code;
  logic wr_valid, up_q, dn_q, up_evt, dn_evt, fa_on;
  logic [SUM_W-1:0] fa_sum;
  logic [CODE_W-1:0] fa_code;

  assign mode   = gain_mode_e'(mode_sel);
  assign up_evt = atten_up & ~up_q;
  assign dn_evt = atten_dn & ~dn_q;
  assign fa_on  = (mode == MODE_SPI) && fast_atk;
  assign fa_sum = {1'b0, prog_code} + SUM_W'(FA_OFFSET);
  assign fa_code = (fa_sum > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : fa_sum[CODE_W-1:0];

  spi_gain_port #(.CODE_W(CODE_W), .FRAME_BITS(FRAME_BITS)) u_spi (
    .clk      (clk),
    .rst      (rst),
    .enable   (pwr_up && (mode == MODE_SPI)),
    .sclk     (spi_sclk),
    .csn      (spi_csn),
    .sdi      (spi_sdi),
    .cur_code (prog_code),
    .wr_valid (wr_valid),
    .wr_code  (wr_code),
    .sdo      (spi_sdo),
    .sdo_oe   (spi_sdo_oe)
  );

  updn_stepper #(.CODE_W(CODE_W), .STEP_SEL_W(STEP_SEL_W)) u_step (
    .cur      (prog_code),
    .up_evt   (up_evt),
    .dn_evt   (dn_evt),
    .step_sel (step_sel),
    .nxt      (step_code)
  );

  always_comb begin
    next_code = prog_code;
    if (pwr_up) begin
      unique case (mode)
        MODE_PAR:  if (!par_hold) next_code = par_code;
        MODE_SPI:  if (wr_valid) next_code = wr_code;
        MODE_UPDN: next_code = step_code;
        default:   next_code = prog_code;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_code <= '0;
      gain_code <= '0;
      amp_en    <= 1'b0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
    end else begin
      up_q      <= atten_up;
      dn_q      <= atten_dn;
      prog_code <= next_code;
      gain_code <= fa_on ? fa_code : prog_code;
      amp_en    <= pwr_up;
    end
  end

  // R11: code frozen while powered down
  a_r11_hold_when_down: assert property (@(posedge clk) disable iff (rst)
    !pwr_up |=> $stable(prog_code));
  // R11: enable follows the power request
  a_r11_enable_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (amp_en == $past(pwr_up)));
  // R10: reserved mode never updates
  a_r10_frozen_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FROZEN) |=> $stable(prog_code));
  // R8: upward step never wraps
  a_r8_up_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UPDN && pwr_up && up_evt && !dn_evt) |=> (prog_code >= $past(prog_code)));
  // R8: downward step never wraps
  a_r8_dn_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UPDN && pwr_up && dn_evt && !up_evt) |=> (prog_code <= $past(prog_code)));
  // R9: simultaneous edges cancel
  a_r9_both_cancel: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UPDN && up_evt && dn_evt) |=> $stable(prog_code));
  // R6: fast attack never lowers attenuation
  a_r6_fa_not_below: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_SPI) && fast_atk) |=> (gain_code >= $past(prog_code)));
  // R6: without fast attack the output mirrors the stored code
  a_r6_release_restores: assert property (@(posedge clk) disable iff (rst)
    !((mode == MODE_SPI) && fast_atk) |=> (gain_code == $past(prog_code)));
endmodule

// File: tb/test_vga_gain_ctrl.sv
module test_vga_gain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic pwr_up = 1'b0;
  logic [5:0] par_code = '0;
  logic par_hold = 1'b1;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe;
  logic fast_atk = 1'b0, atten_up = 1'b0, atten_dn = 1'b0;
  logic [1:0] step_sel = '0;
  logic [5:0] gain_code;
  logic amp_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_gain_ctrl i_vga_gain_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pwr_up(pwr_up),
    .par_code(par_code), .par_hold(par_hold),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .fast_atk(fast_atk),
    .atten_up(atten_up), .atten_dn(atten_dn), .step_sel(step_sel),
    .gain_code(gain_code), .amp_en(amp_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_par(input logic [5:0] c);
    mode_sel = 2'b00; par_code = c; par_hold = 1'b0;
    tick(2);
    par_hold = 1'b1;
    tick(2);
  endtask

  task automatic spi_frame(input int nbits, input logic [15:0] word,
                           input bit rd_chk, input logic [5:0] rd_exp);
    spi_csn = 1'b0;
    tick(HALF_SCLK);
    for (int i = 0; i < nbits; i++) begin
      if (rd_chk && i >= 10 && i <= 15) begin
        chk("R5 sdo_oe", spi_sdo_oe, 1);
        chk("R5 sdo bit", spi_sdo, rd_exp[15-i]);
      end
      spi_sdi = (i < 16) ? word[15-i] : 1'b0;
      tick(HALF_SCLK);
      spi_sclk = 1'b1;
      tick(HALF_SCLK);
      spi_sclk = 1'b0;
    end
    tick(HALF_SCLK);
    spi_csn = 1'b1;
    tick(10);
  endtask

  task automatic pulse(input bit up, input bit dn, input int hold);
    atten_up = up; atten_dn = dn;
    tick(hold);
    atten_up = 1'b0; atten_dn = 1'b0;
    tick(3);
  endtask

  task automatic t_reset;
    tick(1);
    chk("R1 gain_code in reset", gain_code, 0);
    chk("R1 amp_en in reset", amp_en, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 gain_code after reset", gain_code, 0);
    chk("R1 amp_en after reset", amp_en, 0);
    chk("R5 sdo_oe idle", spi_sdo_oe, 0);
    pwr_up = 1'b1;
    tick(2);
  endtask

  task automatic t_parallel;
    mode_sel = 2'b00; par_hold = 1'b0; par_code = 6'd21;
    tick(2);
    chk("R2 transparent", gain_code, 21);
    par_code = 6'd42;
    tick(2);
    chk("R2 follows", gain_code, 42);
    par_hold = 1'b1;
    tick(1);
    par_code = 6'd7;
    tick(3);
    chk("R2 hold", gain_code, 42);
  endtask

  task automatic t_spi_write;
    mode_sel = 2'b01;
    tick(2);
    chk("R10 mode switch keeps code", gain_code, 42);
    spi_frame(16, {1'b0, 9'h1FF, 6'd37}, 0, '0);
    chk("R3 write", gain_code, 37);
    spi_frame(16, {1'b0, 9'h0A5, 6'd12}, 0, '0);
    chk("R3 ignored bits", gain_code, 12);
    spi_frame(16, {1'b0, 9'h000, 6'd37}, 0, '0);
  endtask

  task automatic t_spi_short_long;
    spi_frame(12, {1'b0, 9'h0, 6'd5}, 0, '0);
    chk("R4 short frame", gain_code, 37);
    spi_frame(17, {1'b0, 9'h0, 6'd9}, 0, '0);
    chk("R4 long frame", gain_code, 37);
  endtask

  task automatic t_spi_read;
    spi_frame(16, {1'b1, 9'h0, 6'd3}, 1, 6'd37);
    chk("R5 read keeps code", gain_code, 37);
    chk("R5 sdo_oe released", spi_sdo_oe, 0);
  endtask

  task automatic t_fast_attack;
    fast_atk = 1'b1;
    tick(3);
    chk("R6 offset", gain_code, 45);
    spi_frame(16, {1'b0, 9'h0, 6'd60}, 0, '0);
    chk("R6 saturate", gain_code, 63);
    spi_frame(16, {1'b1, 9'h0, 6'd0}, 1, 6'd60);
    fast_atk = 1'b0;
    tick(3);
    chk("R6 release", gain_code, 60);
    mode_sel = 2'b00; par_hold = 1'b1; fast_atk = 1'b1;
    tick(3);
    chk("R6 no effect in bus mode", gain_code, 60);
    fast_atk = 1'b0;
  endtask

  task automatic t_updn;
    set_par(6'd10);
    mode_sel = 2'b10;
    step_sel = 2'b00; pulse(1, 0, 1); chk("R7 step 1", gain_code, 11);
    step_sel = 2'b01; pulse(1, 0, 1); chk("R7 step 2", gain_code, 13);
    step_sel = 2'b10; pulse(1, 0, 1); chk("R7 step 4", gain_code, 17);
    step_sel = 2'b11; pulse(1, 0, 5); chk("R7 step 8 held", gain_code, 25);
    step_sel = 2'b11; pulse(0, 1, 1); chk("R7 down 8", gain_code, 17);
    step_sel = 2'b10; pulse(0, 1, 1); chk("R7 down 4", gain_code, 13);
  endtask

  task automatic t_saturation;
    set_par(6'd60);
    mode_sel = 2'b10; step_sel = 2'b11;
    pulse(1, 0, 1); chk("R8 top clamp", gain_code, 63);
    pulse(1, 0, 1); chk("R8 top stays", gain_code, 63);
    set_par(6'd3);
    mode_sel = 2'b10; step_sel = 2'b10;
    pulse(0, 1, 1); chk("R8 bottom clamp", gain_code, 0);
    pulse(0, 1, 1); chk("R8 bottom stays", gain_code, 0);
  endtask

  task automatic t_both;
    set_par(6'd20);
    mode_sel = 2'b10; step_sel = 2'b01;
    pulse(1, 1, 1);
    chk("R9 both cancel", gain_code, 20);
  endtask

  task automatic t_frozen;
    mode_sel = 2'b11; par_hold = 1'b0; par_code = 6'd1;
    pulse(1, 0, 1);
    spi_frame(16, {1'b0, 9'h0, 6'd2}, 0, '0);
    chk("R10 frozen mode", gain_code, 20);
    par_hold = 1'b1;
  endtask

  task automatic t_power;
    mode_sel = 2'b00;
    pwr_up = 1'b0;
    tick(1);
    chk("R11 amp_en off", amp_en, 0);
    par_hold = 1'b0; par_code = 6'd50;
    tick(4);
    chk("R11 code kept while down", gain_code, 20);
    par_hold = 1'b1;
    tick(1);
    pwr_up = 1'b1;
    tick(1);
    chk("R11 amp_en on", amp_en, 1);
    tick(2);
    chk("R11 code kept after up", gain_code, 20);
  endtask

  initial begin
    t_reset();
    t_parallel();
    t_spi_write();
    t_spi_short_long();
    t_spi_read();
    t_fast_attack();
    t_updn();
    t_saturation();
    t_both();
    t_frozen();
    t_power();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule